// File: doc/BRIEF.md
# Envelope Buffer and Delay Flag Tracker

This block keeps two status bits for each of 32 sound channels. The buffer-select bit records which of two envelope parameter sets the envelope engine is using for that channel. The delay bit records whether the channel is in a delay phase. During a delay phase the envelope engine keeps running and the channel's sample address engine is held still. Software can change both bits through a small write port. The envelope engine changes them with per-channel buffer-change events, and a per-channel stop pulse clears them.

A register write uses `wr_sel` to pick one of two targets. With `wr_sel` = 0 the write goes to the buffer-select flags: each 1 in the data toggles that channel's flag and raises a one-clock force-switch pulse toward the envelope engine. With `wr_sel` = 1 the write goes to the delay flags: each 1 in the data sets that channel's delay bit. In both cases a 0 in the data leaves the channel alone. A hardware buffer-change event toggles the buffer-select flag. The same event loads the delay bit from the delay attribute of the buffer the engine is moving to.

Top module: `env_buf_delay_flags`

## Requirements
- R1: After a synchronous active-low reset, `buf_sel`, `dly_flag`, `addr_hold` and `force_sw` are all zero.
- R2: A write with `wr_en`=1 and `wr_sel`=0 toggles `buf_sel[n]` for every bit n set in `wr_data`, one clock after the write. Bits whose data is 0 keep their value. A flag value of 0 means buffer 1 is in use and 1 means buffer 2 is in use.
- R3: A pulse on `chg_evt[n]` toggles `buf_sel[n]` one clock later.
- R4: A software toggle and a `chg_evt` pulse on the same channel in the same cycle produce one toggle, not two.
- R5: `force_sw[n]` is high for exactly the one clock after a cycle in which software toggled channel n, and is low otherwise.
- R6: On a `chg_evt[n]` pulse, `dly_flag[n]` takes the value of `chg_dly[n]` one clock later (1 marks a delay-mode buffer). Without an event, a software set or a stop, `dly_flag[n]` holds its value.
- R7: A write with `wr_en`=1 and `wr_sel`=1 sets `dly_flag[n]` for every 1 in `wr_data`, and this set wins over an event that would clear the bit. A 0 in the data changes nothing.
- R8: `addr_hold[n]` equals `dly_flag[n]` in every cycle.
- R9: A `chan_stop[n]` pulse clears `buf_sel[n]` and `dly_flag[n]` one clock later and suppresses `force_sw[n]`. Writes and events on the same channel in the same cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 buffer-select toggle, 1 delay set |
| wr_data | input | 32 | Write data, bit n for channel n |
| chg_evt | input | 32 | Envelope engine buffer-change event per channel |
| chg_dly | input | 32 | Delay attribute of the new buffer, valid with chg_evt |
| chan_stop | input | 32 | Per-channel stop pulse |
| buf_sel | output | 32 | Buffer-select flags (0 buffer 1, 1 buffer 2) |
| dly_flag | output | 32 | Delay-mode flags |
| addr_hold | output | 32 | Address engine hold, high while in delay mode |
| force_sw | output | 32 | One-clock force-switch pulse per channel |

## Verification
The bench drives a software toggle and a hardware event on the same channel in the same cycle. A design that XORs the two sources would leave the flag unchanged, which is wrong. It also drives a stop together with writes and events on the same channels. A design with the wrong priority would leave flags set or emit a stray force pulse. A delay-set write together with an event whose attribute is 0 tests that the set is kept. Random traffic checked against a reference model catches a force pulse that lasts too long, or an event that loads the delay bit of the wrong channel.

// File: rtl/env_flag_pkg.sv
// Package: shared constants and types for the envelope buffer/delay flag block.
// Assumes a single write port whose target is picked by a one-bit select.
package env_flag_pkg;

    // Write target select values
    typedef enum logic {
        TGT_BUF_TOGGLE = 1'b0,
        TGT_DLY_SET    = 1'b1
    } wr_target_e;

    localparam int unsigned DEF_CHANNELS = 32;

endpackage

// File: rtl/env_wr_decode.sv
// Module: env_wr_decode
// Turns one register write into per-channel request vectors: toggle requests
// for the buffer-select flags and set requests for the delay flags.
// Assumes wr_data bit n addresses channel n; the decode is purely combinational.
module env_wr_decode
    import env_flag_pkg::*;
#(
    parameter int unsigned CH = DEF_CHANNELS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CH-1:0] wr_data,
    output logic [CH-1:0] tog_req,
    output logic [CH-1:0] dset_req
);

    // Route the write data to whichever flag set the select names
    always_comb begin
        tog_req  = '0;
        dset_req = '0;
        if (wr_en) begin
            if (wr_sel == TGT_BUF_TOGGLE) tog_req  = wr_data;
            else                          dset_req = wr_data;
        end
    end

    // R2/R7: a single write never feeds both flag sets
    a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !((|tog_req) && (|dset_req)));

    // R7: no delay-set request appears without a delay-target write
    a_r7_dset_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|dset_req) |-> (wr_en && wr_sel));

endmodule

// File: rtl/env_chan_flags.sv
// Module: env_chan_flags
// Flag state for one channel: the buffer-select bit, the delay bit and the
// registered force-switch pulse. Stop has the highest priority. Software and
// hardware toggles in the same cycle merge into one toggle.
// Assumes hw_chg_dly is meaningful only while hw_chg is high.
module env_chan_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_toggle,
    input  logic sw_dly_set,
    input  logic hw_chg,
    input  logic hw_chg_dly,
    input  logic stop,
    output logic buf_q,
    output logic dly_q,
    output logic force_q
);

    // Update the channel flags; stop clears, otherwise toggle and load the delay bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q   <= 1'b0;
            dly_q   <= 1'b0;
            force_q <= 1'b0;
        end else if (stop) begin
            buf_q   <= 1'b0;
            dly_q   <= 1'b0;
            force_q <= 1'b0;
        end else begin
            if (sw_toggle || hw_chg) buf_q <= ~buf_q;
            if (hw_chg)              dly_q <= hw_chg_dly | sw_dly_set;
            else if (sw_dly_set)     dly_q <= 1'b1;
            force_q <= sw_toggle;
        end
    end

    // R4: any toggle source flips the flag exactly once
    a_r4_single_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_toggle || hw_chg) && !stop) |=> (buf_q != $past(buf_q)));

    // R2/R3: with no source and no stop the flag is stable
    a_r3_buf_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_toggle && !hw_chg && !stop) |=> $stable(buf_q));

    // R6: delay bit holds without an event, a set or a stop
    a_r6_dly_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_chg && !sw_dly_set && !stop) |=> $stable(dly_q));

    // R7: a software set always leaves the delay bit high unless stopped
    a_r7_dly_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_dly_set && !stop) |=> dly_q);

    // R5: the force pulse follows a software toggle and lasts one clock
    a_r5_force_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_toggle && !stop) |=> force_q);
    a_r5_force_only_sw: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_toggle |=> !force_q);

    // R9: stop clears both flags and the pulse
    a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!buf_q && !dly_q && !force_q));

endmodule

// File: rtl/env_buf_delay_flags.sv
// Module: env_buf_delay_flags (top)
// Per-channel envelope buffer-select and delay-mode flags for CH channels.
// A write decoder feeds one flag cell per channel. The address engine hold
// output mirrors the delay flag.
// Assumes all inputs are synchronous to clk; stop and events are one-clock pulses.
module env_buf_delay_flags
    import env_flag_pkg::*;
#(
    parameter int unsigned CH = DEF_CHANNELS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CH-1:0] wr_data,
    input  logic [CH-1:0] chg_evt,
    input  logic [CH-1:0] chg_dly,
    input  logic [CH-1:0] chan_stop,
    output logic [CH-1:0] buf_sel,
    output logic [CH-1:0] dly_flag,
    output logic [CH-1:0] addr_hold,
    output logic [CH-1:0] force_sw
);

    logic [CH-1:0] tog_req;
    logic [CH-1:0] dset_req;

    env_wr_decode #(.CH(CH)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tog_req  (tog_req),
        .dset_req (dset_req)
    );

    // One flag cell per channel
    for (genvar g = 0; g < CH; g++) begin : g_ch
        env_chan_flags u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .sw_toggle  (tog_req[g]),
            .sw_dly_set (dset_req[g]),
            .hw_chg     (chg_evt[g]),
            .hw_chg_dly (chg_dly[g]),
            .stop       (chan_stop[g]),
            .buf_q      (buf_sel[g]),
            .dly_q      (dly_flag[g]),
            .force_q    (force_sw[g])
        );
    end

    // Hold the address engine while the channel is in delay mode
    assign addr_hold = dly_flag;

    // R1: everything is idle in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (buf_sel == '0 && dly_flag == '0 && force_sw == '0));

    // R6: an event with a delay attribute lands in the delay flag
    a_r6_evt_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (|(chg_evt & chg_dly & ~chan_stop)) |=> (|dly_flag));

endmodule

// File: tb/sim_env_buf_delay_flags.sv
module sim_env_buf_delay_flags;
    localparam int CLK_PERIOD = 10;
    localparam int CH = 32;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, wr_sel = 0;
    logic [CH-1:0] wr_data = '0, chg_evt = '0, chg_dly = '0, chan_stop = '0;
    logic [CH-1:0] buf_sel, dly_flag, addr_hold, force_sw;

    logic [CH-1:0] e_buf = '0, e_dly = '0, e_frc = '0;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    env_buf_delay_flags #(.CH(CH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .chg_evt(chg_evt), .chg_dly(chg_dly), .chan_stop(chan_stop),
        .buf_sel(buf_sel), .dly_flag(dly_flag), .addr_hold(addr_hold), .force_sw(force_sw)
    );

    function automatic logic [CH-1:0] f_tog(input logic en, input logic sel, input logic [CH-1:0] d);
        return (en && !sel) ? d : '0;
    endfunction
    function automatic logic [CH-1:0] f_set(input logic en, input logic sel, input logic [CH-1:0] d);
        return (en && sel) ? d : '0;
    endfunction

    task automatic chk(input string tag, input logic [CH-1:0] act, input logic [CH-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2 R3 R4 buf_sel"}, buf_sel, e_buf);
        chk({tag, " R6 R7 dly_flag"}, dly_flag, e_dly);
        chk({tag, " R8 addr_hold"}, addr_hold, e_dly);
        chk({tag, " R5 force_sw"}, force_sw, e_frc);
    endtask

    // Apply one cycle of stimulus (at negedge), advance the model, compare after the edge
    task automatic cyc(input logic en, input logic sel, input logic [CH-1:0] d,
                       input logic [CH-1:0] ev, input logic [CH-1:0] ed,
                       input logic [CH-1:0] st, input string tag);
        logic [CH-1:0] t, s;
        wr_en = en; wr_sel = sel; wr_data = d; chg_evt = ev; chg_dly = ed; chan_stop = st;
        t = f_tog(en, sel, d);
        s = f_set(en, sel, d);
        e_buf = (e_buf ^ (t | ev)) & ~st;
        e_dly = (((ev & (ed | s)) | (~ev & (e_dly | s)))) & ~st;
        e_frc = t & ~st;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1 reset");
        rst_n = 1;
        cyc(0, 0, '0, '0, '0, '0, "R1 idle");

        // R2: software toggle then toggle back; zero bits untouched
        cyc(1, 0, 32'h0000_00F1, '0, '0, '0, "R2 toggle");
        cyc(1, 0, 32'h0000_0001, '0, '0, '0, "R2 toggle back");
        cyc(0, 0, '0, '0, '0, '0, "R5 pulse ends");
        // R3: hardware event toggles
        cyc(0, 0, '0, 32'h8000_0000, '0, '0, "R3 hw toggle");
        // R4: sw and hw together on bit 8 -> one toggle
        cyc(1, 0, 32'h0000_0100, 32'h0000_0100, '0, '0, "R4 merged toggle");
        // R6: event with delay attribute sets, then clears
        cyc(0, 0, '0, 32'h0000_0400, 32'h0000_0400, '0, "R6 enter delay");
        cyc(0, 0, '0, '0, '0, '0, "R6 hold");
        cyc(0, 0, '0, 32'h0000_0400, '0, '0, "R6 leave delay");
        // R7: software set, zeros ignored; set beats clearing event
        cyc(1, 1, 32'h0001_0000, '0, '0, '0, "R7 sw set");
        cyc(1, 1, 32'h0000_0000, '0, '0, '0, "R7 zero write");
        cyc(1, 1, 32'h0002_0000, 32'h0002_0000, '0, '0, "R7 set vs clear evt");
        // R9: stop overrides writes and events, no force pulse
        cyc(1, 0, 32'h0000_0001, 32'h0001_0000, 32'h0001_0000, 32'h0001_0001, "R9 stop priority");
        cyc(0, 0, '0, '0, '0, 32'hFFFF_FFFF, "R9 stop all");

        // Random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            logic [CH-1:0] st;
            st = $urandom() & $urandom() & $urandom();
            cyc(1'($urandom()), 1'($urandom()), $urandom(), $urandom() & $urandom(),
                $urandom(), st, "rand R9");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule